// File: doc/BRIEF.md
# Double-Buffered DMA Channel Engine

This block is a multi-channel memory-to-memory copy engine. Each channel holds two register sets: a programmed set (source, destination, byte count) that software writes, and an active set that the engine walks during a transfer. Software can load the next transfer into the programmed set while the current one is still moving data. A second start command then queues it, and the engine switches to it as soon as the current transfer drains, with no idle visit in between.

A tick strobe paces the engine. Each tick services exactly one channel, and the channels take turns in round-robin order. A visit to a running channel with bytes left issues one burst command of at most `BURST_BYTES` on the memory port. A visit that finds the active count at zero completes the transfer. A completion either raises the channel's done flag, which drives the interrupt, or consumes a one-shot suppression token. A fault can be armed per channel: the next visit to that channel while it is running aborts it and raises the error flag instead.

If software writes a channel's registers in the same cycle that the tick visits that channel, the visit does nothing and the write takes effect. The pointer still advances.

Top module: `dbdma_engine`

## Requirements
- R1: After reset every channel is idle (run clear, pending clear), all done and error flags and the register-error bit are clear, `mem_valid_o` and `irq_o` are low, and every control word reads 0.
- R2: A start command (CMD write, bit 0) on an idle channel copies the programmed source, destination and count into the active registers and sets run, which is bit 31 of the control word (read select 3).
- R3: A start command on a running channel sets only pending (control word bit 30) and leaves the active registers unchanged. Pending is never set while run is clear.
- R4: Writes to the programmed source (select 0), destination (select 1) or count (select 2) never change the active registers (read selects 4, 5, 6).
- R5: A visit to a running channel with a nonzero active count issues one memory command of min(count, 2048) bytes from the active addresses. The command is valid in the cycle after the tick edge. The active addresses then advance by that length and the count drops by it.
- R6: Ticks visit channels 0, 1, 2, 3, 0, … one per tick. A visit to an idle channel produces no memory command and changes no state.
- R7: A visit that finds the active count at zero with pending set reloads the active registers from the programmed ones, clears pending and keeps run set. The next visit bursts from the new addresses.
- R8: A visit that finds the active count at zero with pending clear clears run.
- R9: Every completion, whether it chains or stops, sets the channel's done flag (`done_o`, which drives `irq_o`). If the suppression token (control word bit 0) is set, the completion clears the token instead and leaves the done flag unchanged.
- R10: A suppression-token write (select 4) is accepted only with value 1 and only on an idle channel. Any other write leaves the token unchanged and sets the sticky `reg_err_o` bit.
- R11: A stop command (CMD write, bit 1) clears run and pending in the same cycle. Later visits move nothing.
- R12: A fault armed by a CMD write with bit 2 (control word bit 1) makes the next visit to the running channel clear run and pending, issue no memory command and set `err_o` for that channel.
- R13: A flag-clear write (select 5) clears the channel's done flag with bit 0, its error flag with bit 1, and `reg_err_o` with bit 2. `irq_o` is the OR of all done and error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Service strobe, one channel per strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_ch | input | CH_W | Channel addressed by the write |
| reg_sel | input | 3 | Write select: 0 src, 1 dst, 2 count, 3 command, 4 token, 5 flag clear |
| reg_wdata | input | ADDR_W | Write data |
| rd_ch | input | CH_W | Channel addressed by the read |
| rd_sel | input | 3 | Read select: 0–2 programmed, 3 control word, 4–6 active |
| rd_data | output | ADDR_W | Combinational read data |
| mem_valid_o | output | 1 | Memory burst command valid (one cycle) |
| mem_src_o | output | ADDR_W | Burst source address |
| mem_dst_o | output | ADDR_W | Burst destination address |
| mem_len_o | output | CNT_W | Burst length in bytes |
| run_o | output | NUM_CH | Per-channel run state |
| done_o | output | NUM_CH | Per-channel completion flags |
| err_o | output | NUM_CH | Per-channel error flags |
| reg_err_o | output | 1 | Sticky rejected-write status |
| irq_o | output | 1 | Interrupt, OR of all flags |

## Verification
The bench builds the engine with its defaults: four channels, 32-bit addresses, a 16-bit count and 2048-byte bursts. A 5000-byte transfer therefore splits into two full bursts and one 904-byte tail, which exercises the partial-burst length and the extra completion visit. With four channels the round-robin order can be checked, and a queued transfer, a suppressed completion, a stop and an injected fault can each run on a separate channel while the other channels sit idle.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  // write selects
  localparam logic [2:0] WS_PSRC = 3'd0;
  localparam logic [2:0] WS_PDST = 3'd1;
  localparam logic [2:0] WS_PCNT = 3'd2;
  localparam logic [2:0] WS_CMD  = 3'd3;
  localparam logic [2:0] WS_TOKN = 3'd4;
  localparam logic [2:0] WS_FCLR = 3'd5;
  // read selects
  localparam logic [2:0] RS_PSRC = 3'd0;
  localparam logic [2:0] RS_PDST = 3'd1;
  localparam logic [2:0] RS_PCNT = 3'd2;
  localparam logic [2:0] RS_CTRL = 3'd3;
  localparam logic [2:0] RS_ASRC = 3'd4;
  localparam logic [2:0] RS_ADST = 3'd5;
  localparam logic [2:0] RS_ACNT = 3'd6;
  // command bits
  localparam int CMD_GO    = 0;
  localparam int CMD_HALT  = 1;
  localparam int CMD_FAULT = 2;
endpackage

// File: rtl/dbdma_sched.sv
module dbdma_sched #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [NUM_CH-1:0] visit_o
);
  logic [CH_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (tick) begin
      if (ptr_q == CH_W'(NUM_CH - 1)) ptr_d = '0;
      else                            ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (tick) ptr_q <= ptr_d;
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      visit_o[i] = tick && (ptr_q == CH_W'(i));
  end
endmodule

// File: rtl/dbdma_channel.sv
module dbdma_channel
  import dbdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              visit,
  output logic              run_o,
  output logic              pend_o,
  output logic              done_o,
  output logic              err_o,
  output logic              fail_o,
  output logic              tok_o,
  output logic              rej_o,
  output logic [ADDR_W-1:0] psrc_o,
  output logic [ADDR_W-1:0] pdst_o,
  output logic [CNT_W-1:0]  pcnt_o,
  output logic [ADDR_W-1:0] asrc_o,
  output logic [ADDR_W-1:0] adst_o,
  output logic [CNT_W-1:0]  acnt_o,
  output logic              bv_o,
  output logic [CNT_W-1:0]  blen_o
);
  localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST_BYTES);

  logic [ADDR_W-1:0] psrc_q, pdst_q, asrc_q, adst_q;
  logic [ADDR_W-1:0] psrc_d, pdst_d, asrc_d, adst_d;
  logic [CNT_W-1:0]  pcnt_q, acnt_q, pcnt_d, acnt_d;
  logic run_q, pend_q, done_q, err_q, fail_q, tok_q;
  logic run_d, pend_d, done_d, err_d, fail_d, tok_d;
  logic svc, upd;
  logic [CNT_W-1:0] step;

  assign svc  = visit && run_q && !wr_en;
  assign upd  = visit || wr_en;
  assign step = (acnt_q > BURST_C) ? BURST_C : acnt_q;

  always_comb begin
    psrc_d = psrc_q; pdst_d = pdst_q; pcnt_d = pcnt_q;
    asrc_d = asrc_q; adst_d = adst_q; acnt_d = acnt_q;
    run_d = run_q; pend_d = pend_q; done_d = done_q;
    err_d = err_q; fail_d = fail_q; tok_d = tok_q;
    bv_o = 1'b0; blen_o = '0; rej_o = 1'b0;

    if (svc) begin
      if (fail_q) begin
        fail_d = 1'b0;
        run_d  = 1'b0;
        pend_d = 1'b0;
        err_d  = 1'b1;
      end else if (acnt_q == '0) begin
        if (pend_q) begin
          asrc_d = psrc_q;
          adst_d = pdst_q;
          acnt_d = pcnt_q;
          pend_d = 1'b0;
        end else begin
          run_d = 1'b0;
        end
        if (tok_q) tok_d  = 1'b0;
        else       done_d = 1'b1;
      end else begin
        bv_o   = 1'b1;
        blen_o = step;
        acnt_d = acnt_q - step;
        asrc_d = asrc_q + ADDR_W'(step);
        adst_d = adst_q + ADDR_W'(step);
      end
    end

    if (wr_en) begin
      case (wr_sel)
        WS_PSRC: psrc_d = wr_data;
        WS_PDST: pdst_d = wr_data;
        WS_PCNT: pcnt_d = wr_data[CNT_W-1:0];
        WS_CMD: begin
          if (wr_data[CMD_HALT]) begin
            run_d  = 1'b0;
            pend_d = 1'b0;
          end else if (wr_data[CMD_GO]) begin
            if (run_q) begin
              pend_d = 1'b1;
            end else begin
              asrc_d = psrc_q;
              adst_d = pdst_q;
              acnt_d = pcnt_q;
              run_d  = 1'b1;
            end
          end
          if (wr_data[CMD_FAULT]) fail_d = 1'b1;
        end
        WS_TOKN: begin
          if (!run_q && wr_data == ADDR_W'(1)) tok_d = 1'b1;
          else                                 rej_o = 1'b1;
        end
        WS_FCLR: begin
          if (wr_data[0]) done_d = 1'b0;
          if (wr_data[1]) err_d  = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psrc_q <= '0; pdst_q <= '0; pcnt_q <= '0;
      asrc_q <= '0; adst_q <= '0; acnt_q <= '0;
      run_q <= 1'b0; pend_q <= 1'b0; done_q <= 1'b0;
      err_q <= 1'b0; fail_q <= 1'b0; tok_q <= 1'b0;
    end else if (upd) begin
      psrc_q <= psrc_d; pdst_q <= pdst_d; pcnt_q <= pcnt_d;
      asrc_q <= asrc_d; adst_q <= adst_d; acnt_q <= acnt_d;
      run_q <= run_d; pend_q <= pend_d; done_q <= done_d;
      err_q <= err_d; fail_q <= fail_d; tok_q <= tok_d;
    end
  end

  assign run_o  = run_q;
  assign pend_o = pend_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign fail_o = fail_q;
  assign tok_o  = tok_q;
  assign psrc_o = psrc_q;
  assign pdst_o = pdst_q;
  assign pcnt_o = pcnt_q;
  assign asrc_o = asrc_q;
  assign adst_o = adst_q;
  assign acnt_o = acnt_q;
endmodule

// File: rtl/dbdma_engine.sv
module dbdma_engine
  import dbdma_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 2048,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic [CH_W-1:0]   reg_ch,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [2:0]        rd_sel,
  output logic [ADDR_W-1:0] rd_data,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_src_o,
  output logic [ADDR_W-1:0] mem_dst_o,
  output logic [CNT_W-1:0]  mem_len_o,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] done_o,
  output logic [NUM_CH-1:0] err_o,
  output logic              reg_err_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] visit_v, pend_v, fail_v, tok_v, rej_v, bv_v;
  logic [ADDR_W-1:0] psrc_a [NUM_CH];
  logic [ADDR_W-1:0] pdst_a [NUM_CH];
  logic [ADDR_W-1:0] asrc_a [NUM_CH];
  logic [ADDR_W-1:0] adst_a [NUM_CH];
  logic [CNT_W-1:0]  pcnt_a [NUM_CH];
  logic [CNT_W-1:0]  acnt_a [NUM_CH];
  logic [CNT_W-1:0]  blen_a [NUM_CH];

  dbdma_sched #(.NUM_CH(NUM_CH)) u_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .visit_o(visit_v)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dbdma_channel #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES)
    ) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && (reg_ch == CH_W'(g))),
      .wr_sel(reg_sel), .wr_data(reg_wdata),
      .visit(visit_v[g]),
      .run_o(run_o[g]), .pend_o(pend_v[g]), .done_o(done_o[g]),
      .err_o(err_o[g]), .fail_o(fail_v[g]), .tok_o(tok_v[g]),
      .rej_o(rej_v[g]),
      .psrc_o(psrc_a[g]), .pdst_o(pdst_a[g]), .pcnt_o(pcnt_a[g]),
      .asrc_o(asrc_a[g]), .adst_o(adst_a[g]), .acnt_o(acnt_a[g]),
      .bv_o(bv_v[g]), .blen_o(blen_a[g])
    );
  end

  // burst command select: at most one channel is visited per tick
  logic              bv_any;
  logic [ADDR_W-1:0] bsrc, bdst;
  logic [CNT_W-1:0]  blen;
  always_comb begin
    bv_any = |bv_v;
    bsrc = '0; bdst = '0; blen = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bv_v[i]) begin
        bsrc = asrc_a[i];
        bdst = adst_a[i];
        blen = blen_a[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid_o <= 1'b0;
      mem_src_o   <= '0;
      mem_dst_o   <= '0;
      mem_len_o   <= '0;
    end else begin
      mem_valid_o <= bv_any;
      if (bv_any) begin
        mem_src_o <= bsrc;
        mem_dst_o <= bdst;
        mem_len_o <= blen;
      end
    end
  end

  // sticky rejected-write status
  logic reg_err_d;
  logic fclr_reg_err;
  assign fclr_reg_err = reg_wr && (reg_sel == WS_FCLR) && reg_wdata[2];
  always_comb begin
    reg_err_d = reg_err_o;
    if (fclr_reg_err) reg_err_d = 1'b0;
    if (|rej_v)       reg_err_d = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_err_o <= 1'b0;
    else        reg_err_o <= reg_err_d;
  end

  assign irq_o = (|done_o) || (|err_o);

  // read port
  always_comb begin
    rd_data = '0;
    case (rd_sel)
      RS_PSRC: rd_data = psrc_a[rd_ch];
      RS_PDST: rd_data = pdst_a[rd_ch];
      RS_PCNT: rd_data = ADDR_W'(pcnt_a[rd_ch]);
      RS_CTRL: begin
        rd_data[ADDR_W-1] = run_o[rd_ch];
        rd_data[ADDR_W-2] = pend_v[rd_ch];
        rd_data[1]        = fail_v[rd_ch];
        rd_data[0]        = tok_v[rd_ch];
      end
      RS_ASRC: rd_data = asrc_a[rd_ch];
      RS_ADST: rd_data = adst_a[rd_ch];
      RS_ACNT: rd_data = ADDR_W'(acnt_a[rd_ch]);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dbdma_engine_chk.sv
module dbdma_engine_chk
  import dbdma_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 2048,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [CH_W-1:0]   reg_ch,
  input logic [2:0]        reg_sel,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic              mem_valid_o,
  input logic [CNT_W-1:0]  mem_len_o,
  input logic [NUM_CH-1:0] run_o,
  input logic [NUM_CH-1:0] err_o,
  input logic [NUM_CH-1:0] pend_v,
  input logic [NUM_CH-1:0] visit_v,
  input logic              reg_err_o
);
  assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> (mem_len_o != '0 && mem_len_o <= CNT_W'(BURST_BYTES)));

  assert_single_visit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(visit_v));

  assert_reject_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == WS_TOKN && reg_wdata != ADDR_W'(1)) |=> reg_err_o);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    assert_pend_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v[g] |-> run_o[g]);

    assert_stop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_ch == CH_W'(g) && reg_sel == WS_CMD && reg_wdata[CMD_HALT])
      |=> (!run_o[g] && !pend_v[g]));

    assert_fault_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o[g]) |-> ($past(run_o[g]) && !run_o[g]));
  end
endmodule

bind dbdma_engine dbdma_engine_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ch(reg_ch),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .mem_valid_o(mem_valid_o),
  .mem_len_o(mem_len_o), .run_o(run_o), .err_o(err_o), .pend_v(pend_v),
  .visit_v(visit_v), .reg_err_o(reg_err_o)
);

// File: tb/dbdma_engine_tb.sv
module dbdma_engine_tb;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_ch = '0;
  logic [2:0] reg_sel = '0;
  logic [ADDR_W-1:0] reg_wdata = '0;
  logic [1:0] rd_ch = '0;
  logic [2:0] rd_sel = '0;
  logic [ADDR_W-1:0] rd_data;
  logic mem_valid_o;
  logic [ADDR_W-1:0] mem_src_o, mem_dst_o;
  logic [CNT_W-1:0] mem_len_o;
  logic [NUM_CH-1:0] run_o, done_o, err_o;
  logic reg_err_o, irq_o;

  int errors = 0;
  int checks = 0;
  int exp_ptr = 0;

  always #4 clk = ~clk;

  dbdma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_ch(reg_ch),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_ch(rd_ch), .rd_sel(rd_sel),
    .rd_data(rd_data), .mem_valid_o(mem_valid_o), .mem_src_o(mem_src_o),
    .mem_dst_o(mem_dst_o), .mem_len_o(mem_len_o), .run_o(run_o),
    .done_o(done_o), .err_o(err_o), .reg_err_o(reg_err_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_ch = 2'(ch); reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [2:0] sel, output logic [31:0] v);
    rd_ch = 2'(ch); rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    exp_ptr = (exp_ptr + 1) % NUM_CH;
  endtask

  // tick until channel c has just been visited
  task automatic visit(input int c);
    while (exp_ptr != c) do_tick();
    do_tick();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 run", 32'(run_o), 0);
    check("R1 done", 32'(done_o), 0);
    check("R1 err", 32'(err_o), 0);
    check("R1 irq", 32'(irq_o), 0);
    check("R1 mem_valid", 32'(mem_valid_o), 0);
    check("R1 reg_err", 32'(reg_err_o), 0);
    rd(2, 3'd3, v); check("R1 ctrl", v, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    wr(0, 3'd0, 32'h1000); wr(0, 3'd1, 32'h2000); wr(0, 3'd2, 5000);
    wr(0, 3'd3, 32'h1);
    rd(0, 3'd3, v); check("R2 run bit31", v, 32'h8000_0000);
    rd(0, 3'd4, v); check("R2 asrc", v, 32'h1000);
    rd(0, 3'd6, v); check("R2 acnt", v, 5000);
    visit(0);
    check("R5 valid", 32'(mem_valid_o), 1);
    check("R5 len", 32'(mem_len_o), 2048);
    check("R5 src", mem_src_o, 32'h1000);
    check("R5 dst", mem_dst_o, 32'h2000);
    rd(0, 3'd6, v); check("R5 acnt", v, 2952);
    rd(0, 3'd5, v); check("R5 adst", v, 32'h2800);
    do_tick();
    check("R6 idle ch1 no burst", 32'(mem_valid_o), 0);
    visit(0);
    check("R5 second src", mem_src_o, 32'h1800);
    check("R6 order back to ch0", 32'(mem_len_o), 2048);
    visit(0);
    check("R5 tail len", 32'(mem_len_o), 904);
    rd(0, 3'd6, v); check("R5 acnt zero", v, 0);
    check("R8 still running", 32'(run_o[0]), 1);
    visit(0);
    check("R8 run cleared", 32'(run_o[0]), 0);
    check("R8 no burst", 32'(mem_valid_o), 0);
    check("R9 done", 32'(done_o[0]), 1);
    check("R9 irq", 32'(irq_o), 1);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    wr(1, 3'd0, 32'h100); wr(1, 3'd1, 32'h200); wr(1, 3'd2, 16);
    wr(1, 3'd3, 32'h1);
    wr(1, 3'd0, 32'h300); wr(1, 3'd1, 32'h400); wr(1, 3'd2, 8);
    rd(1, 3'd4, v); check("R4 asrc kept", v, 32'h100);
    rd(1, 3'd6, v); check("R4 acnt kept", v, 16);
    wr(1, 3'd3, 32'h1);
    rd(1, 3'd3, v); check("R3 pending", v, 32'hC000_0000);
    rd(1, 3'd5, v); check("R3 adst kept", v, 32'h200);
    visit(1);
    check("R5 ch1 src", mem_src_o, 32'h100);
    check("R5 ch1 len", 32'(mem_len_o), 16);
    visit(1);
    rd(1, 3'd3, v); check("R7 run kept pend cleared", v, 32'h8000_0000);
    rd(1, 3'd4, v); check("R7 asrc reload", v, 32'h300);
    check("R9 chain done", 32'(done_o[1]), 1);
    visit(1);
    check("R7 new src", mem_src_o, 32'h300);
    check("R7 new dst", mem_dst_o, 32'h400);
    check("R7 new len", 32'(mem_len_o), 8);
    visit(1);
    check("R8 ch1 stops", 32'(run_o[1]), 0);
  endtask

  task automatic t_token();
    logic [31:0] v;
    wr(2, 3'd4, 3);
    check("R10 reject value", 32'(reg_err_o), 1);
    rd(2, 3'd3, v); check("R10 token unchanged", v, 0);
    wr(2, 3'd5, 32'h4);
    check("R13 reg_err cleared", 32'(reg_err_o), 0);
    wr(2, 3'd4, 1);
    rd(2, 3'd3, v); check("R10 token accepted", v, 1);
    check("R10 no error", 32'(reg_err_o), 0);
    wr(2, 3'd0, 32'h40); wr(2, 3'd1, 32'h80); wr(2, 3'd2, 4);
    wr(2, 3'd3, 32'h1);
    wr(2, 3'd4, 1);
    check("R10 reject while running", 32'(reg_err_o), 1);
    visit(2);
    check("R5 ch2 len", 32'(mem_len_o), 4);
    visit(2);
    check("R9 done suppressed", 32'(done_o[2]), 0);
    rd(2, 3'd3, v); check("R9 token consumed", v, 0);
    wr(2, 3'd5, 32'h4);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(3, 3'd0, 32'h5000); wr(3, 3'd1, 32'h6000); wr(3, 3'd2, 4000);
    wr(3, 3'd3, 32'h1); wr(3, 3'd3, 32'h1);
    rd(3, 3'd3, v); check("R11 pre run+pend", v, 32'hC000_0000);
    wr(3, 3'd3, 32'h2);
    rd(3, 3'd3, v); check("R11 both cleared", v, 0);
    visit(3);
    check("R11 no burst", 32'(mem_valid_o), 0);
    rd(3, 3'd6, v); check("R6 idle visit no change", v, 4000);
  endtask

  task automatic t_fault();
    logic [31:0] v;
    wr(0, 3'd5, 32'h3);
    check("R13 done cleared", 32'(done_o[0]), 0);
    wr(0, 3'd3, 32'h4);
    rd(0, 3'd3, v); check("R12 armed", v, 32'h2);
    wr(0, 3'd2, 100);
    wr(0, 3'd3, 32'h1);
    visit(0);
    check("R12 no burst", 32'(mem_valid_o), 0);
    check("R12 err flag", 32'(err_o[0]), 1);
    check("R12 run cleared", 32'(run_o[0]), 0);
    check("R13 irq from err", 32'(irq_o), 1);
  endtask

  task automatic t_clear();
    for (int c = 0; c < NUM_CH; c++) wr(c, 3'd5, 32'h7);
    check("R13 done all clear", 32'(done_o), 0);
    check("R13 err all clear", 32'(err_o), 0);
    check("R13 irq low", 32'(irq_o), 0);
    check("R13 reg_err low", 32'(reg_err_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_chain();
    t_token();
    t_stop();
    t_fault();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule